// File: doc/BRIEF.md
# DES Round Subkey Generator

This block turns a 64-bit DES key into the sixteen 48-bit round subkeys. It delivers one subkey per clock cycle over sixteen consecutive cycles that begin one cycle after a start strobe. The bits in the least significant position of every key byte are parity bits, and the generator discards them. It keeps the remaining 56 bits as two 28-bit halves. Before each round it rotates both halves, then selects 48 of the 56 bits to form that round's subkey.

A direction input is sampled with the start strobe. For encryption the halves rotate left and the subkeys come out in round order. For decryption the halves rotate right on a mirrored schedule, so the same subkeys come out in reverse order. The reversed order is produced on the fly, and no subkey is ever stored. A cipher datapath that runs one round per cycle uses each subkey in the cycle where it is marked valid.

Top module: `des_subkey_gen`

## Requirements
- R1: While reset is held and after it is released with no start, `subkey_valid` is 0 and `subkey` is all zeros.
- R2: A start sampled at a clock edge makes `subkey_valid` 1 from that edge for exactly 16 cycles, after which it returns to 0.
- R3: Key bits 56, 48, 40, 32, 24, 16, 8 and 0 (the LSB of each byte) have no effect on any subkey.
- R4: With `decrypt` = 0 at start, cycle n of the valid window (n = 1..16) carries subkey Kn. The halves are rotated left by a cumulative total before each selection, and the per-round amounts are 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1.
- R5: With `decrypt` = 1 at start, cycle n of the valid window carries K(17-n), so K16 comes first and K1 comes last. This is done by rotating right by 0,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1.
- R6: Whenever `subkey_valid` is 0, `subkey` is all zeros.
- R7: A start during a running sequence abandons it. The next cycle carries the first subkey of the new key and direction, and the new sequence runs for 16 cycles.
- R8: Bit numbering follows the standard tables with DES bit 1 as the MSB. `key[63]` is key bit 1 and `subkey[47]` is subkey bit 1. For key 0x133457799BBCDFF1, K1 = 0x1B02EFFC7072 and K16 = 0xCB3D8B0E17F5.
- R9: `decrypt` and `key` are sampled only with start. Changing them during a sequence does not change its subkeys.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new subkey sequence with the present key and direction |
| decrypt | input | 1 | 0: forward order K1..K16; 1: reverse order K16..K1 |
| key | input | 64 | DES key including parity bits, bit 63 = DES bit 1 |
| subkey | output | 48 | Round subkey, bit 47 = subkey bit 1; zero when not valid |
| subkey_valid | output | 1 | High for the 16 cycles of a sequence |

## Verification
Each round is rotated from the state the previous round left behind. An error in one rotation amount or direction therefore shows on `subkey` in the cycle of that round and corrupts every later subkey of the sequence, which a round-by-round comparison catches at once. A wrong round counter shows as a valid window that is not exactly 16 cycles, visible in cycle 16 or 17. The bench sweeps every single-bit key in both directions, so each key bit, including the parity bits, is traced to its subkey positions in every round.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;
    localparam int KEY_W  = 64;
    localparam int CD_W   = 56;
    localparam int HALF_W = CD_W / 2;
    localparam int SUB_W  = 48;
    localparam int ROUNDS = 16;
    localparam int RND_W  = $clog2(ROUNDS);
    localparam int IDX_W  = $clog2(KEY_W);

    // key-bit selection into the 56-bit state, DES numbering (1 = MSB)
    localparam int PC1_TAB [CD_W] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };

    // 56-to-48 selection of the rotated state
    localparam int PC2_TAB [SUB_W] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    typedef struct packed {
        logic [HALF_W-1:0] c;
        logic [HALF_W-1:0] d;
        logic [RND_W-1:0]  rnd;
        logic              busy;
        logic              dec;
    } ks_state_t;

    // rotation applied before round rnd (1..ROUNDS); reverse order skips round 1
    function automatic logic [1:0] shift_amt(input int rnd, input logic dec);
        if (dec && rnd == 1)
            return 2'd0;
        if (rnd == 1 || rnd == 2 || rnd == 9 || rnd == ROUNDS)
            return 2'd1;
        return 2'd2;
    endfunction
endpackage

// File: rtl/des_ks_pc1.sv
module des_ks_pc1
    import des_ks_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    output logic [CD_W-1:0]  cd_o
);
    always_comb begin
        cd_o = '0;
        for (int i = 0; i < CD_W; i++) begin
            cd_o[IDX_W'(CD_W - 1 - i)] = key_i[IDX_W'(KEY_W - PC1_TAB[i])];
        end
    end
endmodule

// File: rtl/des_ks_rot.sv
module des_ks_rot #(
    parameter int W = 28
) (
    input  logic [W-1:0] half_i,
    input  logic [1:0]   amt_i,
    input  logic         left_i,
    output logic [W-1:0] half_o
);
    always_comb begin
        unique case (amt_i)
            2'd1:    half_o = left_i ? {half_i[W-2:0], half_i[W-1]}
                                     : {half_i[0], half_i[W-1:1]};
            2'd2:    half_o = left_i ? {half_i[W-3:0], half_i[W-1:W-2]}
                                     : {half_i[1:0], half_i[W-1:2]};
            default: half_o = half_i;
        endcase
    end
endmodule

// File: rtl/des_ks_pc2.sv
module des_ks_pc2
    import des_ks_pkg::*;
(
    input  logic [CD_W-1:0]  cd_i,
    output logic [SUB_W-1:0] sub_o
);
    always_comb begin
        sub_o = '0;
        for (int j = 0; j < SUB_W; j++) begin
            sub_o[IDX_W'(SUB_W - 1 - j)] = cd_i[IDX_W'(CD_W - PC2_TAB[j])];
        end
    end
endmodule

// File: rtl/des_subkey_gen.sv
module des_subkey_gen
    import des_ks_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        decrypt,
    input  logic [63:0] key,
    output logic [47:0] subkey,
    output logic        subkey_valid
);
    ks_state_t st_d, st_q;

    logic [CD_W-1:0]  pc1_cd;
    logic [CD_W-1:0]  src_cd;
    logic [CD_W-1:0]  rot_cd;
    logic [1:0]       step_amt;
    logic             step_left;
    logic [SUB_W-1:0] pc2_sub;

    des_ks_pc1 u_pc1 (
        .key_i (key),
        .cd_o  (pc1_cd)
    );

    // the start path and the step path share one rotator per half
    always_comb begin
        if (start) begin
            src_cd    = pc1_cd;
            step_amt  = shift_amt(1, decrypt);
            step_left = ~decrypt;
        end else begin
            src_cd    = {st_q.c, st_q.d};
            step_amt  = shift_amt(int'(st_q.rnd) + 2, st_q.dec);
            step_left = ~st_q.dec;
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        des_ks_rot #(.W(HALF_W)) u_rot (
            .half_i (src_cd[h*HALF_W +: HALF_W]),
            .amt_i  (step_amt),
            .left_i (step_left),
            .half_o (rot_cd[h*HALF_W +: HALF_W])
        );
    end

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.c    = rot_cd[CD_W-1:HALF_W];
            st_d.d    = rot_cd[HALF_W-1:0];
            st_d.rnd  = '0;
            st_d.busy = 1'b1;
            st_d.dec  = decrypt;
        end else if (st_q.busy) begin
            if (st_q.rnd == RND_W'(ROUNDS - 1)) begin
                st_d.busy = 1'b0;
                st_d.rnd  = '0;
            end else begin
                st_d.rnd = st_q.rnd + 1'b1;
                st_d.c   = rot_cd[CD_W-1:HALF_W];
                st_d.d   = rot_cd[HALF_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    des_ks_pc2 u_pc2 (
        .cd_i  ({st_q.c, st_q.d}),
        .sub_o (pc2_sub)
    );

    assign subkey_valid = st_q.busy;
    assign subkey       = st_q.busy ? pc2_sub : '0;
endmodule

// File: rtl/des_subkey_gen_chk.sv
module des_subkey_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [47:0] subkey,
    input logic        subkey_valid
);
    logic [4:0] run;

    // number of the present valid cycle within its sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run <= '0;
        else if (start)
            run <= 5'd1;
        else if (subkey_valid)
            run <= run + 5'd1;
        else
            run <= '0;
    end

    assert_start_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> subkey_valid);

    assert_window_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(subkey_valid) |-> $past(run) == 5'd16);

    assert_no_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (subkey_valid && run == 5'd16 && !start) |=> !subkey_valid);

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !subkey_valid |-> subkey == 48'd0);

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && subkey_valid) |=> (subkey_valid && run == 5'd1));
endmodule

bind des_subkey_gen des_subkey_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .subkey       (subkey),
    .subkey_valid (subkey_valid)
);

// File: tb/des_subkey_gen_tb.sv
module des_subkey_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        decrypt = 1'b0;
    logic [63:0] key = '0;
    logic [47:0] subkey;
    logic        subkey_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    des_subkey_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .decrypt      (decrypt),
        .key          (key),
        .subkey       (subkey),
        .subkey_valid (subkey_valid)
    );

    int sel56 [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,
                       10,2,59,51,43,35,27,19,11,3,60,52,44,36,
                       63,55,47,39,31,23,15,7,62,54,46,38,30,22,
                       14,6,61,53,45,37,29,21,13,5,28,20,12,4};
    int sel48 [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,
                       23,19,12,4,26,8,16,7,27,20,13,2,
                       41,52,31,37,47,55,30,40,51,45,33,48,
                       44,49,39,56,34,53,46,42,50,36,29,32};
    int lshift [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};

    logic [47:0] exp_k [16];

    // forward key schedule in DES bit numbering, bit 1 = MSB
    task automatic model(input logic [63:0] k);
        logic [27:0] c, d;
        logic [55:0] cd;
        for (int i = 0; i < 56; i++) cd[55-i] = k[64-sel56[i]];
        c = cd[55:28];
        d = cd[27:0];
        for (int r = 0; r < 16; r++) begin
            for (int s = 0; s < lshift[r]; s++) begin
                c = {c[26:0], c[27]};
                d = {d[26:0], d[27]};
            end
            cd = {c, d};
            for (int j = 0; j < 48; j++) exp_k[r][47-j] = cd[56-sel48[j]];
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // start a sequence; optionally disturb inputs after start (R9)
    task automatic run_seq(input logic [63:0] k, input logic dec, input bit disturb,
                           input string req);
        model(k);
        @(negedge clk);
        start = 1'b1; key = k; decrypt = dec;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin decrypt = ~dec; key = ~k; end
        for (int r = 0; r < 16; r++) begin
            check(subkey_valid === 1'b1, {req, " R2 valid"}, 64'(subkey_valid), 64'd1);
            check(subkey === exp_k[dec ? 15 - r : r], req, 64'(subkey),
                  64'(exp_k[dec ? 15 - r : r]));
            @(negedge clk);
        end
        check(subkey_valid === 1'b0, "R2 end of window", 64'(subkey_valid), 64'd0);
        check(subkey === 48'd0, "R6 idle zero", 64'(subkey), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] lf;
        logic [47:0] zk [16];
        repeat (3) @(negedge clk);
        check(subkey_valid === 1'b0, "R1 reset valid", 64'(subkey_valid), 64'd0);
        check(subkey === 48'd0, "R1 reset subkey", 64'(subkey), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(subkey_valid === 1'b0, "R1 idle after reset", 64'(subkey_valid), 64'd0);

        // R8 known answer
        run_seq(64'h133457799BBCDFF1, 1'b0, 1'b0, "R4");
        model(64'h133457799BBCDFF1);
        check(exp_k[0] === 48'h1B02EFFC7072, "R8 model K1", 64'(exp_k[0]), 64'h1B02EFFC7072);
        @(negedge clk); start = 1'b1; key = 64'h133457799BBCDFF1; decrypt = 1'b0;
        @(negedge clk); start = 1'b0;
        check(subkey === 48'h1B02EFFC7072, "R8 K1", 64'(subkey), 64'h1B02EFFC7072);
        repeat (15) @(negedge clk);
        check(subkey === 48'hCB3D8B0E17F5, "R8 K16", 64'(subkey), 64'hCB3D8B0E17F5);
        @(negedge clk);
        run_seq(64'h133457799BBCDFF1, 1'b1, 1'b0, "R5");
        @(negedge clk); start = 1'b1; decrypt = 1'b1;
        @(negedge clk); start = 1'b0;
        check(subkey === 48'hCB3D8B0E17F5, "R8 R5 reverse first", 64'(subkey), 64'hCB3D8B0E17F5);
        repeat (16) @(negedge clk);

        // single-bit sweep, both orders
        for (int b = 0; b < 64; b++) begin
            run_seq(64'd1 << b, 1'b0, 1'b0, "R4 sweep");
            run_seq(64'd1 << b, 1'b1, 1'b0, "R5 sweep");
        end

        // R3: parity bits alone give the all-zero key's subkeys
        model(64'd0);
        zk = exp_k;
        @(negedge clk); start = 1'b1; key = 64'h0101010101010101; decrypt = 1'b0;
        @(negedge clk); start = 1'b0;
        for (int r = 0; r < 16; r++) begin
            check(subkey === zk[r], "R3 parity ignored", 64'(subkey), 64'(zk[r]));
            @(negedge clk);
        end

        // pseudo-random keys, with R9 input disturbance on some
        lf = 64'hA5F0_3C96_1E87_D24B;
        for (int t = 0; t < 12; t++) begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            run_seq(lf, t[0], t[1], t[1] ? "R9 disturbed" : "R4/R5 random");
        end

        // R7: restart mid-sequence with new key and reverse order
        @(negedge clk); start = 1'b1; key = 64'h0123456789ABCDEF; decrypt = 1'b0;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        model(64'hFEDCBA9876543210);
        start = 1'b1; key = 64'hFEDCBA9876543210; decrypt = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int r = 0; r < 16; r++) begin
            check(subkey_valid === 1'b1 && subkey === exp_k[15 - r], "R7 restart",
                  64'(subkey), 64'(exp_k[15 - r]));
            @(negedge clk);
        end
        check(subkey_valid === 1'b0, "R7 restart window end", 64'(subkey_valid), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule